// File: doc/BRIEF.md
# Programmable Raster Border Timing Generator

This block produces the raster timing for a video output from a set of programmed positions. A horizontal counter runs across each line and a vertical counter across each field; both wrap at programmed totals. From the two counts the block derives the sync pulses, a visible region bounded by a border start and stop in each axis, and an active display window. The window begins at a programmed column and line and extends to the border stop. While the window is active, the block also reports the pixel coordinates within it.

Software programs the block through a simple write port with a register select. Every write lands in a pending copy. The live (shadow) copy is reloaded from the pending copy only at the start of vertical blanking, and a one-clock interrupt marks that moment. As a result, mode changes, pan updates and blank changes never tear a frame. The block also provides:
- Interlaced scan, with a field flag that picks one of two vertical window starts.
- Scanline doubling and horizontal pixel doubling.
- A blank control that stretches the border over the whole visible area.

Top module: `raster_border_gen`

## Requirements
- R1: Horizontal sync is high while the horizontal count is below the horizontal border start. The count runs 0..htotal-1 and then wraps to 0. Write select 0 sets htotal in data[15:0] and vtotal in data[31:16].
- R2: Vertical sync is high while the line count is below the vertical border start. The line count advances at each line wrap and wraps to 0 after line vtotal-1.
- R3: A position is visible when its column is in [hb_start, hb_stop) and its line is in [vb_start, vb_stop). Border_active is high for a visible position that is outside the window. Write select 1 sets hb_start in [31:16] and hb_stop in [15:0]; write select 2 sets the vertical pair in the same layout.
- R4: Window_active is high for a column in [win_h, hb_stop) and a line in [win_v, vb_stop). In that case pix_x = column - win_h and pix_y = line - win_v; both are 0 outside the window. Write select 3 sets win_h in [15:0].
- R5: With blank set (write select 5, bit 3), window_active stays low and border_active covers the whole visible area. Clearing the bit restores the window.
- R6: Writes change nothing seen at the outputs until the shadow load. The load happens on the clock whose column is 0 and whose line equals the live vb_stop; vblank_irq is high for exactly that one clock. A write sampled in that same clock waits for the next load.
- R7: With interlace set (write select 7, bit 4), the field flag toggles at every frame wrap. Without interlace it is cleared at the frame wrap. Write select 4 sets the field-0 (long field) window start line in [31:16] and the field-1 start line in [15:0]. Field 1 uses the lower half only when interlace is set.
- R8: With pixel doubling set (write select 5, bit 0), pix_x is (column - win_h) >> 1.
- R9: With interlace set, pix_y = 2*(line - win_v) + field. Otherwise, with scan doubling set (write select 6, bit 1), pix_y = (line - win_v) >> 1.
- R10: With video enable clear (write select 7, bit 8), hsync, vsync, border_active and window_active are all low. With display enable clear (write select 6, bit 0), border_active and window_active are low while the syncs continue.
- R11: While reset is high, both counters and the field are 0, and the parameter defaults are in force. The defaults have video and display enabled and every other mode off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register select |
| wr_data | input | 32 | Register write data |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| border_active | output | 1 | Position is in the border |
| window_active | output | 1 | Position is in the display window |
| field | output | 1 | Current field |
| pix_x | output | 16 | Column within the window |
| pix_y | output | 16 | Row within the window |
| vblank_irq | output | 1 | One-clock retrace pulse at shadow load |

## Verification
The hardest case to reach is a write whose sampling clock is the load clock itself. Such a write must miss that load and take effect one frame later. The stimulus waits at a falling edge until vblank_irq is seen high, then issues the write in that same cycle, so the rising edge samples it together with the load. A cycle-accurate reference model predicts the outputs on every clock. The stimulus also measures the sync pulse width just before and just after a retrace, which shows directly that a pending value stays hidden until the load.

// File: rtl/raster_pkg.sv
package raster_pkg;

    localparam int CW = 16;
    localparam int DW = 32;
    localparam int SW = 4;

    typedef enum logic [SW-1:0] {
        SEL_TOTALS  = 4'd0,
        SEL_HBORDER = 4'd1,
        SEL_VBORDER = 4'd2,
        SEL_WIN_H   = 4'd3,
        SEL_WIN_V   = 4'd4,
        SEL_WINCFG  = 4'd5,
        SEL_MODE    = 4'd6,
        SEL_SYNCCFG = 4'd7
    } reg_sel_e;

    typedef struct packed {
        logic [CW-1:0] htot;
        logic [CW-1:0] vtot;
        logic [CW-1:0] hb_start;
        logic [CW-1:0] hb_stop;
        logic [CW-1:0] vb_start;
        logic [CW-1:0] vb_stop;
        logic [CW-1:0] win_h;
        logic [CW-1:0] win_v_long;
        logic [CW-1:0] win_v_short;
        logic          blank;
        logic          hdouble;
        logic          disp_en;
        logic          scandouble;
        logic          video_en;
        logic          interlace;
    } cfg_t;

    typedef struct packed {
        logic [CW-1:0] hc;
        logic [CW-1:0] vc;
        logic          field;
    } raster_pos_t;

    function automatic cfg_t apply_write(cfg_t c, logic [SW-1:0] sel, logic [DW-1:0] d);
        cfg_t n = c;
        case (reg_sel_e'(sel))
            SEL_TOTALS:  begin n.vtot = d[16 +: CW]; n.htot = d[0 +: CW]; end
            SEL_HBORDER: begin n.hb_start = d[16 +: CW]; n.hb_stop = d[0 +: CW]; end
            SEL_VBORDER: begin n.vb_start = d[16 +: CW]; n.vb_stop = d[0 +: CW]; end
            SEL_WIN_H:   n.win_h = d[0 +: CW];
            SEL_WIN_V:   begin n.win_v_long = d[16 +: CW]; n.win_v_short = d[0 +: CW]; end
            SEL_WINCFG:  begin n.blank = d[3]; n.hdouble = d[0]; end
            SEL_MODE:    begin n.disp_en = d[0]; n.scandouble = d[1]; end
            SEL_SYNCCFG: begin n.video_en = d[8]; n.interlace = d[4]; end
            default:     n = c;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/raster_regs.sv
module raster_regs
    import raster_pkg::*;
#(
    parameter cfg_t RST_CFG = '0
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [SW-1:0]  wr_sel,
    input  logic [DW-1:0]  wr_data,
    input  logic           load,
    output cfg_t           shadow
);

    cfg_t pending;

    always_ff @(posedge clk) begin
        if (rst)
            pending <= RST_CFG;
        else if (wr_en)
            pending <= apply_write(pending, wr_sel, wr_data);
    end

    always_ff @(posedge clk) begin
        if (rst)
            shadow <= RST_CFG;
        else if (load)
            shadow <= pending;
    end

    // R6: live settings only move on a retrace load
    p_shadow_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(shadow));

endmodule

// File: rtl/raster_counters.sv
module raster_counters
    import raster_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  cfg_t        cfg,
    output raster_pos_t pos,
    output logic        load,
    output logic        frame_end
);

    logic [CW-1:0] h_last;
    logic [CW-1:0] v_last;
    logic          line_end;

    assign h_last    = cfg.htot - CW'(1);
    assign v_last    = cfg.vtot - CW'(1);
    assign line_end  = (pos.hc >= h_last);
    assign frame_end = line_end && (pos.vc >= v_last);
    assign load      = (pos.hc == '0) && (pos.vc == cfg.vb_stop);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else if (line_end) begin
            pos.hc <= '0;
            if (frame_end) begin
                pos.vc    <= '0;
                pos.field <= cfg.interlace ? ~pos.field : 1'b0;
            end else begin
                pos.vc <= pos.vc + CW'(1);
            end
        end else begin
            pos.hc <= pos.hc + CW'(1);
        end
    end

    // R1: column returns to zero after the last count
    p_hwrap_r1: assert property (@(posedge clk) disable iff (rst)
        line_end |=> (pos.hc == '0));

    // R7: field only moves on a frame wrap
    p_field_stable_r7: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> $stable(pos.field));

    // R6: the retrace pulse lasts a single clock
    p_irq_single_r6: assert property (@(posedge clk) disable iff (rst)
        (load && cfg.htot > CW'(1)) |=> !load);

endmodule

// File: rtl/raster_decode.sv
module raster_decode
    import raster_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  cfg_t          cfg,
    input  raster_pos_t   pos,
    output logic          hsync,
    output logic          vsync,
    output logic          border_active,
    output logic          window_active,
    output logic [CW-1:0] pix_x,
    output logic [CW-1:0] pix_y
);

    logic          vis_h, vis_v, visible;
    logic          in_win;
    logic          use_short;
    logic [CW-1:0] win_v;
    logic [CW-1:0] dx, dy;

    assign use_short = cfg.interlace & pos.field;
    assign win_v     = use_short ? cfg.win_v_short : cfg.win_v_long;

    assign vis_h   = (pos.hc >= cfg.hb_start) && (pos.hc < cfg.hb_stop);
    assign vis_v   = (pos.vc >= cfg.vb_start) && (pos.vc < cfg.vb_stop);
    assign visible = vis_h && vis_v;
    assign in_win  = (pos.hc >= cfg.win_h) && (pos.hc < cfg.hb_stop) &&
                     (pos.vc >= win_v)     && (pos.vc < cfg.vb_stop);

    assign dx = pos.hc - cfg.win_h;
    assign dy = pos.vc - win_v;

    always_comb begin
        hsync         = cfg.video_en && (pos.hc < cfg.hb_start);
        vsync         = cfg.video_en && (pos.vc < cfg.vb_start);
        window_active = cfg.video_en && cfg.disp_en && !cfg.blank && in_win;
        border_active = cfg.video_en && cfg.disp_en && visible && !window_active;
        pix_x = '0;
        pix_y = '0;
        if (window_active) begin
            pix_x = cfg.hdouble ? (dx >> 1) : dx;
            if (cfg.interlace)
                pix_y = {dy[CW-2:0], pos.field};
            else if (cfg.scandouble)
                pix_y = dy >> 1;
            else
                pix_y = dy;
        end
    end

    // R4: border and window never overlap
    p_excl_r4: assert property (@(posedge clk) disable iff (rst)
        window_active |-> !border_active);

    // R5: blanking removes the window entirely
    p_blank_r5: assert property (@(posedge clk) disable iff (rst)
        cfg.blank |-> !window_active);

    // R10: nothing drives out while video is disabled
    p_video_off_r10: assert property (@(posedge clk) disable iff (rst)
        !cfg.video_en |-> !(hsync || vsync || border_active || window_active));

endmodule

// File: rtl/raster_border_gen.sv
module raster_border_gen
    import raster_pkg::*;
#(
    parameter int DEF_HTOTAL   = 20,
    parameter int DEF_VTOTAL   = 12,
    parameter int DEF_HB_START = 2,
    parameter int DEF_HB_STOP  = 18,
    parameter int DEF_VB_START = 1,
    parameter int DEF_VB_STOP  = 10,
    parameter int DEF_WIN_H    = 4,
    parameter int DEF_WIN_V0   = 3,
    parameter int DEF_WIN_V1   = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [3:0]     wr_sel,
    input  logic [31:0]    wr_data,
    output logic           hsync,
    output logic           vsync,
    output logic           border_active,
    output logic           window_active,
    output logic           field,
    output logic [15:0]    pix_x,
    output logic [15:0]    pix_y,
    output logic           vblank_irq
);

    localparam cfg_t RST_CFG = '{
        htot:        CW'(DEF_HTOTAL),
        vtot:        CW'(DEF_VTOTAL),
        hb_start:    CW'(DEF_HB_START),
        hb_stop:     CW'(DEF_HB_STOP),
        vb_start:    CW'(DEF_VB_START),
        vb_stop:     CW'(DEF_VB_STOP),
        win_h:       CW'(DEF_WIN_H),
        win_v_long:  CW'(DEF_WIN_V0),
        win_v_short: CW'(DEF_WIN_V1),
        blank:       1'b0,
        hdouble:     1'b0,
        disp_en:     1'b1,
        scandouble:  1'b0,
        video_en:    1'b1,
        interlace:   1'b0
    };

    cfg_t        live_cfg;
    raster_pos_t pos;
    logic        load;
    logic        frame_end;

    raster_regs #(.RST_CFG(RST_CFG)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .load    (load),
        .shadow  (live_cfg)
    );

    raster_counters u_cnt (
        .clk       (clk),
        .rst       (rst),
        .cfg       (live_cfg),
        .pos       (pos),
        .load      (load),
        .frame_end (frame_end)
    );

    raster_decode u_dec (
        .clk           (clk),
        .rst           (rst),
        .cfg           (live_cfg),
        .pos           (pos),
        .hsync         (hsync),
        .vsync         (vsync),
        .border_active (border_active),
        .window_active (window_active),
        .pix_x         (pix_x),
        .pix_y         (pix_y)
    );

    assign field      = pos.field;
    assign vblank_irq = load;

    // R2: line count stays put within a line, so vsync only moves at column 0
    p_vsync_line_r2: assert property (@(posedge clk) disable iff (rst)
        (pos.hc != '0) |-> $stable(vsync) || $past(load) || $changed(live_cfg));

endmodule

// File: tb/tb_raster_border_gen.sv
module tb_raster_border_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        hsync, vsync, border_active, window_active, field, vblank_irq;
    logic [15:0] pix_x, pix_y;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    raster_border_gen dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .hsync(hsync), .vsync(vsync), .border_active(border_active),
        .window_active(window_active), .field(field), .pix_x(pix_x),
        .pix_y(pix_y), .vblank_irq(vblank_irq)
    );

    typedef struct {
        int ht, vt, hbs, hbe, vbs, vbe, wh, wv0, wv1;
        bit blank, hdbl, den, sdbl, ven, ilace;
    } mcfg_t;

    typedef struct {
        bit hs, vs, bd, win, fld, irq;
        int px, py;
    } exp_t;

    mcfg_t pend, shad;
    int mh, mv;
    bit mf;
    exp_t q[$];

    function automatic mcfg_t defaults();
        mcfg_t c;
        c.ht = 20; c.vt = 12; c.hbs = 2; c.hbe = 18; c.vbs = 1; c.vbe = 10;
        c.wh = 4; c.wv0 = 3; c.wv1 = 4;
        c.blank = 0; c.hdbl = 0; c.den = 1; c.sdbl = 0; c.ven = 1; c.ilace = 0;
        return c;
    endfunction

    function automatic mcfg_t mwrite(mcfg_t c, int sel, logic [31:0] d);
        mcfg_t n = c;
        case (sel)
            0: begin n.vt = d[31:16]; n.ht = d[15:0]; end
            1: begin n.hbs = d[31:16]; n.hbe = d[15:0]; end
            2: begin n.vbs = d[31:16]; n.vbe = d[15:0]; end
            3: n.wh = d[15:0];
            4: begin n.wv0 = d[31:16]; n.wv1 = d[15:0]; end
            5: begin n.blank = d[3]; n.hdbl = d[0]; end
            6: begin n.den = d[0]; n.sdbl = d[1]; end
            7: begin n.ven = d[8]; n.ilace = d[4]; end
            default: ;
        endcase
        return n;
    endfunction

    function automatic exp_t predict(int h, int v, bit f, mcfg_t s);
        exp_t e;
        int wv;
        bit vis, inw;
        wv  = (s.ilace && f) ? s.wv1 : s.wv0;
        vis = (h >= s.hbs) && (h < s.hbe) && (v >= s.vbs) && (v < s.vbe);
        inw = (h >= s.wh) && (h < s.hbe) && (v >= wv) && (v < s.vbe);
        e.hs  = s.ven && (h < s.hbs);
        e.vs  = s.ven && (v < s.vbs);
        e.win = s.ven && s.den && !s.blank && inw;
        e.bd  = s.ven && s.den && vis && !e.win;
        e.fld = f;
        e.irq = (h == 0) && (v == s.vbe);
        e.px = 0; e.py = 0;
        if (e.win) begin
            e.px = s.hdbl ? (h - s.wh) / 2 : (h - s.wh);
            if (s.ilace) e.py = 2 * (v - wv) + f;
            else if (s.sdbl) e.py = (v - wv) / 2;
            else e.py = v - wv;
        end
        return e;
    endfunction

    // reference model: advances on each rising edge, pushes the expected outputs
    always @(posedge clk) begin
        if (rst) begin
            pend = defaults(); shad = defaults();
            mh = 0; mv = 0; mf = 0;
        end else begin
            bit ld;
            ld = (mh == 0) && (mv == shad.vbe);
            if (mh >= shad.ht - 1) begin
                mh = 0;
                if (mv >= shad.vt - 1) begin
                    mv = 0;
                    mf = shad.ilace ? !mf : 1'b0;
                end else mv = mv + 1;
            end else mh = mh + 1;
            if (ld) shad = pend;
            if (wr_en) pend = mwrite(pend, int'(wr_sel), wr_data);
        end
        q.push_back(predict(mh, mv, mf, shad));
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // scoreboard monitor: compares each predicted cycle away from the edge
    always @(negedge clk) begin
        if (q.size() > 0 && !done) begin
            exp_t e;
            e = q.pop_front();
            chk(hsync == e.hs, "R1 hsync", int'(hsync), int'(e.hs));
            chk(vsync == e.vs, "R2 vsync", int'(vsync), int'(e.vs));
            chk(border_active == e.bd, "R3 border", int'(border_active), int'(e.bd));
            chk(window_active == e.win, "R4 window", int'(window_active), int'(e.win));
            chk(field == e.fld, "R7 field", int'(field), int'(e.fld));
            chk(vblank_irq == e.irq, "R6 irq", int'(vblank_irq), int'(e.irq));
            chk(int'(pix_x) == e.px, "R8 pix_x", int'(pix_x), e.px);
            chk(int'(pix_y) == e.py, "R9 pix_y", int'(pix_y), e.py);
        end
    end

    task automatic wr(int sel, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 4'(sel); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic watch(int n, output int hs, output int bd, output int win);
        hs = 0; bd = 0; win = 0;
        repeat (n) begin
            @(negedge clk);
            hs  += int'(hsync);
            bd  += int'(border_active);
            win += int'(window_active);
        end
    endtask

    task automatic wait_irq();
        do @(negedge clk); while (!vblank_irq);
    endtask

    task automatic hsync_run(output int len);
        len = 0;
        do @(negedge clk); while (hsync);
        do @(negedge clk); while (!hsync);
        while (hsync) begin len++; @(negedge clk); end
    endtask

    initial begin
        int hs, bd, win, len;
        repeat (3) @(negedge clk);
        // R11: reset state with defaults in force
        chk(hsync == 1'b1 && vsync == 1'b1, "R11 reset syncs", int'({hsync, vsync}), 3);
        chk(window_active == 0 && field == 0 && vblank_irq == 0, "R11 reset outputs",
            int'({window_active, field, vblank_irq}), 0);
        rst = 1'b0;
        repeat (500) @(negedge clk);

        // R6: pending border start hidden until the retrace
        wr(1, {16'd5, 16'd18});
        hsync_run(len);
        chk(len == 2, "R6 hsync before load", len, 2);
        wait_irq();
        hsync_run(len);
        chk(len == 5, "R6 hsync after load", len, 5);
        wr(1, {16'd2, 16'd18});
        repeat (500) @(negedge clk);

        // R7: interlace, two window starts
        wr(7, 32'h110);
        repeat (1200) @(negedge clk);

        // R5: blank
        wr(5, 32'h8);
        wait_irq();
        watch(240, hs, bd, win);
        chk(win == 0, "R5 no window while blanked", win, 0);
        chk(bd == 16 * 9, "R5 border covers visible area", bd, 16 * 9);
        wr(5, 32'h0);
        repeat (500) @(negedge clk);

        // R8, R9: doubling, progressive
        wr(7, 32'h100);
        wr(5, 32'h1);
        wr(6, 32'h3);
        repeat (800) @(negedge clk);

        // R10: display off, then video off
        wr(6, 32'h0);
        wait_irq();
        watch(240, hs, bd, win);
        chk(bd == 0 && win == 0, "R10 display off", bd + win, 0);
        chk(hs == 2 * 12, "R10 syncs continue", hs, 24);
        wr(7, 32'h0);
        wait_irq();
        watch(240, hs, bd, win);
        chk(hs == 0, "R10 video off hsync", hs, 0);
        wr(7, 32'h100);
        wr(6, 32'h1);
        wr(5, 32'h0);
        repeat (500) @(negedge clk);

        // R1, R2: new totals and borders
        wr(0, {16'd14, 16'd24});
        wr(1, {16'd2, 16'd22});
        wr(2, {16'd1, 16'd12});
        wr(4, {16'd3, 16'd3});
        repeat (1200) @(negedge clk);

        // R6: write sampled in the same clock as the load waits one frame
        wait_irq();
        wr_en = 1'b1; wr_sel = 4'd1; wr_data = {16'd6, 16'd22};
        @(negedge clk);
        wr_en = 1'b0;
        hsync_run(len);
        chk(len == 2, "R6 coincident write deferred", len, 2);
        wait_irq();
        hsync_run(len);
        chk(len == 6, "R6 coincident write applied", len, 6);
        repeat (400) @(negedge clk);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule